// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block turns four power-mode bits, held next to the CPU status flags, into the clock controls for a small processor. The outputs are a CPU clock gate and three clock-domain enables: the fast digitally controlled oscillator, the sub-main peripheral clock and the slow auxiliary clock. Software enters a sleep mode by writing the mode bits. The CPU clock gate closes and the selected clock domains switch off.

When the interrupt logic accepts a request, the controller saves the current mode bits. It then forces the CPU and its clocks back on so the handler can run. The handler may rewrite the saved copy. On return, the saved copy becomes the live mode again, so the part either sleeps again or stays awake. If the CPU must restart while the fast oscillator was stopped, the CPU clock stays gated for a programmable number of settle cycles. A one-cycle wake pulse marks the cycle in which the CPU clock request comes back.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is applied and after its synchronous release, the mode bits read 0, all three clock enables are 1, the CPU clock gate is 1 and the wake output is 0.
- R2: A software write (sr_wr) loads sr_wdata into the mode bits at the next rising edge. The bit map is: bit 0 CPU off, bit 1 slow oscillator off, bit 2 fast generator off, bit 3 peripheral clock off.
- R3: The enables follow the mode bits that the same edge loads: aclk_en = !bit1, smclk_en = !bit3, dco_en = !(bit2 & bit0). Mode 4'h1 keeps all three enables on. Mode 4'hD leaves only aclk_en on. Mode 4'hF turns all three off.
- R4: The CPU clock gate changes only on the falling clock edge. It is 0 whenever the registered mode has bit 0 set.
- R5: When an interrupt is accepted outside a handler, the mode bits are copied to the saved copy and bits 0, 1 and 3 clear at the next edge. Bit 2 keeps its value.
- R6: Only one handler level exists. An irq_accept while a handler is active is ignored.
- R7: Inside a handler, saved_wr replaces the saved copy. irq_return loads the saved copy into the mode bits. If saved_wr comes in the same cycle as irq_return, the newly written value is the one loaded.
- R8: Bit 0 can clear while dco_en is 0. The internal CPU run request then stays low for settle_cycles rising edges after that edge. The gate opens at the falling edge that follows. A value of 0, or an oscillator that is already running, gives no extra delay. If bit 0 is set again, a pending settle is cancelled.
- R9: wake is high for exactly one cycle, in the cycle after the run request goes from 0 to 1.
- R10: irq_accept takes priority over sr_wr in the same cycle, and that write is dropped. irq_return also takes priority over sr_wr. Outside a handler, irq_return and saved_wr have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| settle_cycles | input | CNT_W | Settle delay applied when the CPU restarts from a stopped oscillator |
| sr_wr | input | 1 | Software write strobe for the mode bits |
| sr_wdata | input | 4 | Mode bits to write |
| irq_accept | input | 1 | Interrupt accepted, enter the handler |
| irq_return | input | 1 | Handler returns |
| saved_wr | input | 1 | Handler write strobe for the saved mode copy |
| saved_wdata | input | 4 | New saved mode copy |
| mode_bits | output | 4 | Live mode bits |
| cpu_clk_gate | output | 1 | CPU clock gate, updated on the falling edge |
| dco_en | output | 1 | Fast oscillator enable |
| smclk_en | output | 1 | Sub-main peripheral clock enable |
| aclk_en | output | 1 | Slow auxiliary clock enable |
| wake | output | 1 | One-cycle pulse when the CPU run request returns |

## Verification
Two kinds of event can land in the same cycle. First, a handler return can coincide with a rewrite of the saved copy; the bench expects the new value to win. Second, an interrupt acceptance can coincide with a software mode write; the bench expects the write to be lost and the pre-edge mode to be saved. Both pairs are driven as directed cases, and the random phase produces them again and again with different settle lengths. A bench reference model judges every cycle for mode bits, enables, gate and wake.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;
  localparam int MODE_W     = 4;
  localparam int B_CPUOFF   = 0;
  localparam int B_OSCOFF   = 1;
  localparam int B_GENOFF   = 2;
  localparam int B_PERIOFF  = 3;

  typedef logic [MODE_W-1:0] mode_t;

  // bits kept on interrupt entry: only the fast generator control survives
  localparam mode_t ENTRY_KEEP = mode_t'(1) << B_GENOFF;

  typedef struct packed {
    logic dco;
    logic smclk;
    logic aclk;
  } clk_en_t;

  function automatic clk_en_t decode_enables(mode_t m);
    clk_en_t e;
    e.dco   = !(m[B_GENOFF] && m[B_CPUOFF]);
    e.smclk = !m[B_PERIOFF];
    e.aclk  = !m[B_OSCOFF];
    return e;
  endfunction
endpackage

// File: rtl/pwr_rst_sync.sv
`timescale 1ns/1ps
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_mode_regs.sv
`timescale 1ns/1ps
module pwr_mode_regs
  import pwr_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  ret_req,
  input  logic  sw_wr,
  input  mode_t sw_bits,
  input  logic  sav_wr,
  input  mode_t sav_bits,
  output mode_t mode_q,
  output mode_t mode_d,
  output logic  isr_q
);
  mode_t sav_q, sav_d;
  logic  isr_d;

  always_comb begin
    mode_d = mode_q;
    sav_d  = sav_q;
    isr_d  = isr_q;
    if (take) begin
      sav_d  = mode_q;
      mode_d = mode_q & ENTRY_KEEP;
      isr_d  = 1'b1;
    end else if (ret_req && isr_q) begin
      mode_d = sav_wr ? sav_bits : sav_q;
      isr_d  = 1'b0;
    end else begin
      if (sw_wr)            mode_d = sw_bits;
      if (sav_wr && isr_q)  sav_d  = sav_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sav_q  <= '0;
      isr_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sav_q  <= sav_d;
      isr_q  <= isr_d;
    end
  end
endmodule

// File: rtl/pwr_clk_dec.sv
`timescale 1ns/1ps
module pwr_clk_dec
  import pwr_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_d,
  output logic  dco_q,
  output logic  smclk_q,
  output logic  aclk_q
);
  clk_en_t en_d;

  always_comb begin
    en_d = decode_enables(mode_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dco_q   <= 1'b1;
      smclk_q <= 1'b1;
      aclk_q  <= 1'b1;
    end else begin
      dco_q   <= en_d.dco;
      smclk_q <= en_d.smclk;
      aclk_q  <= en_d.aclk;
    end
  end
endmodule

// File: rtl/pwr_settle.sv
`timescale 1ns/1ps
module pwr_settle
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            mode_q,
  input  mode_t            mode_d,
  input  logic             dco_q,
  input  logic [CNT_W-1:0] settle_len,
  output logic             run_q,
  output logic             wake_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_d, wake_d;
  logic             cold_start;

  always_comb begin
    cold_start = mode_q[B_CPUOFF] && !mode_d[B_CPUOFF] && !dco_q;
    if (cold_start)               cnt_d = settle_len;
    else if (mode_d[B_CPUOFF])    cnt_d = '0;
    else if (cnt_q != '0)         cnt_d = cnt_q - ONE;
    else                          cnt_d = '0;
    run_d  = !mode_d[B_CPUOFF] && (cnt_d == '0);
    wake_d = run_d && !run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b1;
      wake_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      wake_q <= wake_d;
    end
  end
endmodule

// File: rtl/pwr_cpu_gate.sv
`timescale 1ns/1ps
module pwr_cpu_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic gate_q
);
  // update while the clock is low so the gated clock never sees a runt pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= run;
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
`timescale 1ns/1ps
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             sr_wr,
  input  logic [3:0]       sr_wdata,
  input  logic             irq_accept,
  input  logic             irq_return,
  input  logic             saved_wr,
  input  logic [3:0]       saved_wdata,
  output logic [3:0]       mode_bits,
  output logic             cpu_clk_gate,
  output logic             dco_en,
  output logic             smclk_en,
  output logic             aclk_en,
  output logic             wake
);
  logic  rst_s_n;
  logic  in_isr;
  logic  take;
  mode_t mode_q, mode_d;
  logic  run_q;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  assign take = irq_accept && !in_isr;

  pwr_mode_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .take(take), .ret_req(irq_return),
    .sw_wr(sr_wr), .sw_bits(sr_wdata), .sav_wr(saved_wr),
    .sav_bits(saved_wdata), .mode_q(mode_q), .mode_d(mode_d), .isr_q(in_isr)
  );

  pwr_clk_dec u_dec (
    .clk(clk), .rst_n(rst_s_n), .mode_d(mode_d),
    .dco_q(dco_en), .smclk_q(smclk_en), .aclk_q(aclk_en)
  );

  pwr_settle #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_s_n), .mode_q(mode_q), .mode_d(mode_d),
    .dco_q(dco_en), .settle_len(settle_cycles), .run_q(run_q), .wake_q(wake)
  );

  pwr_cpu_gate u_gate (
    .clk(clk), .rst_n(rst_s_n), .run(run_q), .gate_q(cpu_clk_gate)
  );

  assign mode_bits = mode_q;
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_isr,
  input logic             run_q,
  input logic [CNT_W-1:0] settle_cycles,
  input logic             sr_wr,
  input logic             irq_accept,
  input logic             irq_return,
  input logic             saved_wr,
  input logic [3:0]       saved_wdata,
  input logic [3:0]       mode_bits,
  input logic             cpu_clk_gate,
  input logic             dco_en,
  input logic             smclk_en,
  input logic             aclk_en,
  input logic             wake
);
  a_r3_deep_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 4'hF) |-> (!dco_en && !smclk_en && !aclk_en));

  a_r4_gate_off_when_cpuoff: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bits[0] |-> !cpu_clk_gate);

  a_r5_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept && !in_isr) |=> (mode_bits[0] == 1'b0 && mode_bits[1] == 1'b0 &&
                                 mode_bits[3] == 1'b0 && mode_bits[2] == $past(mode_bits[2])));

  a_r6_nested_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept && in_isr && !irq_return && !sr_wr) |=> $stable(mode_bits));

  a_r7_return_takes_new_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && in_isr && saved_wr) |=> (mode_bits == $past(saved_wdata)));

  a_r8_cold_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept && !in_isr && !dco_en && settle_cycles != '0) |=> !run_q);

  a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .in_isr(in_isr), .run_q(run_q),
  .settle_cycles(settle_cycles), .sr_wr(sr_wr), .irq_accept(irq_accept),
  .irq_return(irq_return), .saved_wr(saved_wr), .saved_wdata(saved_wdata),
  .mode_bits(mode_bits), .cpu_clk_gate(cpu_clk_gate), .dco_en(dco_en),
  .smclk_en(smclk_en), .aclk_en(aclk_en), .wake(wake)
);

// File: tb/pwr_mode_ctl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctl_test;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] settle_cycles;
  logic             sr_wr, irq_accept, irq_return, saved_wr;
  logic [3:0]       sr_wdata, saved_wdata;
  logic [3:0]       mode_bits;
  logic             cpu_clk_gate, dco_en, smclk_en, aclk_en, wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic [3:0]       m_mode, m_sav;
  logic             m_isr, m_run, m_wake;
  logic [CNT_W-1:0] m_cnt;
  logic [2:0]       m_en;

  always #4 clk = ~clk;

  pwr_mode_ctl #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .irq_accept(irq_accept),
    .irq_return(irq_return), .saved_wr(saved_wr), .saved_wdata(saved_wdata),
    .mode_bits(mode_bits), .cpu_clk_gate(cpu_clk_gate), .dco_en(dco_en),
    .smclk_en(smclk_en), .aclk_en(aclk_en), .wake(wake)
  );

  function automatic logic [2:0] exp_en(logic [3:0] m);
    return {!(m[2] && m[0]), !m[3], !m[1]};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R2/R5/R7/R10 mode bits", {4'h0, mode_bits}, {4'h0, m_mode});
    chk("R3 enables {dco,smclk,aclk}", {5'h0, dco_en, smclk_en, aclk_en}, {5'h0, m_en});
    chk("R4/R8 cpu gate", {7'h0, cpu_clk_gate}, {7'h0, m_run});
    chk("R9 wake", {7'h0, wake}, {7'h0, m_wake});
  endtask

  task automatic step(input logic sw, input logic [3:0] swb, input logic acc,
                      input logic ret, input logic svw, input logic [3:0] svb);
    logic [3:0]       nm, ns;
    logic             ni, nr;
    logic [CNT_W-1:0] nc;
    sr_wr = sw; sr_wdata = swb; irq_accept = acc; irq_return = ret;
    saved_wr = svw; saved_wdata = svb;
    nm = m_mode; ns = m_sav; ni = m_isr;
    if (acc && !m_isr) begin
      ns = m_mode; nm = m_mode & 4'b0100; ni = 1'b1;
    end else if (ret && m_isr) begin
      nm = svw ? svb : m_sav; ni = 1'b0;
    end else begin
      if (sw) nm = swb;
      if (svw && m_isr) ns = svb;
    end
    if (m_mode[0] && !nm[0] && !m_en[2]) nc = settle_cycles;
    else if (nm[0])                      nc = '0;
    else if (m_cnt != '0)                nc = m_cnt - CNT_W'(1);
    else                                 nc = '0;
    nr = !nm[0] && (nc == '0);
    @(posedge clk);
    m_wake = nr && !m_run;
    m_mode = nm; m_sav = ns; m_isr = ni; m_cnt = nc; m_run = nr;
    m_en = exp_en(nm);
    @(negedge clk);
    #1;
    chk_all();
  endtask

  task automatic idle();
    step(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; settle_cycles = '0;
    sr_wr = 0; sr_wdata = 0; irq_accept = 0; irq_return = 0; saved_wr = 0; saved_wdata = 0;
    m_mode = 0; m_sav = 0; m_isr = 0; m_run = 1; m_wake = 0; m_cnt = 0; m_en = 3'b111;
    repeat (3) @(negedge clk);
    #1;
    // R1: state while reset is held
    chk("R1 reset mode", {4'h0, mode_bits}, 8'h00);
    chk("R1 reset enables/gate/wake", {4'h0, dco_en, smclk_en, aclk_en, cpu_clk_gate} ^ {7'h0, wake}, 8'h0F);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk_all();

    // R3/R4: deep sleep turns everything off
    step(1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 4'h0);
    chk("R3 deep sleep enables", {5'h0, dco_en, smclk_en, aclk_en}, 8'h00);
    // R5/R8: cold start with a settle of 4
    settle_cycles = 8'd4;
    step(1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0);
    chk("R5 entry keeps only bit 2", {4'h0, mode_bits}, 8'h04);
    held = 0;
    while (!cpu_clk_gate && held < 20) begin
      idle();
      held++;
    end
    chk("R8 settle length", 8'(held), 8'd4);
    // R6: nested accept ignored
    step(1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0);
    chk("R6 nested accept", {4'h0, mode_bits}, 8'h04);
    // R7: saved write in the same cycle as return
    step(1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 4'h1);
    chk("R7 return with same-cycle write", {4'h0, mode_bits}, 8'h01);
    chk("R3 light sleep enables", {5'h0, dco_en, smclk_en, aclk_en}, 8'h07);
    // R8/R9: warm start, no settle, wake pulse
    step(1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0);
    chk("R9 wake pulse on warm start", {7'h0, wake}, 8'h01);
    idle();
    chk("R9 wake drops", {7'h0, wake}, 8'h00);
    step(1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h0);
    // R10: accept beats software write
    step(1'b1, 4'hD, 1'b1, 1'b0, 1'b0, 4'h0);
    chk("R10 write dropped at entry", {4'h0, mode_bits}, 8'h00);
    step(1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h0);
    chk("R10 return restores pre-entry mode", {4'h0, mode_bits}, 8'h01);
    // R10: return and saved write outside a handler do nothing
    step(1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 4'hF);
    chk("R10 stray return", {4'h0, mode_bits}, 8'h01);

    // random phase, reference model checks every cycle
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] wv;
      if (i % 64 == 0) settle_cycles = CNT_W'($urandom_range(0, 6));
      case ($urandom_range(0, 4))
        0: wv = 4'h0;
        1: wv = 4'h1;
        2: wv = 4'hD;
        3: wv = 4'hF;
        default: wv = 4'($urandom);
      endcase
      step($urandom_range(0, 3) == 0, wv,
           $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 5) == 0, 4'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule